// File: doc/BRIEF.md
# Multiplexed-Bus Target Port with Endian-Selectable Byte Lanes

This block is the slave side of a 32-bit multiplexed address/data bus. It watches the active-low frame strobe to find the address phase and decodes the command from the command/byte-enable lines in that clock. It claims the cycle by pulling device select low, then completes data phases through the initiator-ready / target-ready handshake. Single and burst accesses reach a small word-organised storage array in memory space. In configuration space they reach one base-address register, which places the memory window on the bus.

A burst keeps a word pointer that steps by one after each completed data phase. Write byte lanes are gated by the active-low enables. A runtime endian input chooses how bus lanes map onto storage bytes. The block drives output-enable flags instead of tri-state pins, and reset clears them all.

Top module: `pci_tgt_core`

## Requirements
- R1: While `rst_n` is low (sampled on the rising edge), `devsel_n` and `trdy_n` are high and `ad_oe` and `ctl_oe` are low. The base register resets to parameter `BAR_INIT`, and all storage words reset to zero.
- R2: The address phase is the first rising edge in idle with `frame_n` low. A memory read (`cbe_n`=4'b0110) or memory write (4'b0111) whose address bits [31:AW] equal the base register bits [31:AW] is claimed: `devsel_n` and `trdy_n` go low in the next clock. AW = log2(WORDS)+2.
- R3: A memory command outside the window, or any command other than the four decoded ones, is never claimed. `devsel_n` stays high for the whole transaction and storage is unchanged.
- R4: Configuration read (4'b1010) and write (4'b1011) with address bits [1:0]=00 are claimed only when `idsel` is high in the address phase. The base register sits at configuration byte offset 0x10, its bits [AW-1:0] read as zero, and every other configuration offset reads as zero and ignores writes.
- R5: A data word moves only on a rising edge where `irdy_n` and `trdy_n` are both low. An edge with `irdy_n` high writes nothing and leaves the word pointer unchanged.
- R6: The word pointer loads from address bits [7:2] and advances by one after every completed data phase. Memory accesses use its low log2(WORDS) bits, so a burst wraps around the storage.
- R7: In data phases the `cbe_n` bits are active-low lane enables. In little-endian mode (`big_endian`=0), bit i gates bus bits [8i+7:8i], and that bus lane holds storage byte i.
- R8: In big-endian mode (`big_endian`=1), bus lane i (bits [8i+7:8i], gated by `cbe_n[i]`) holds storage byte 3-i, for both writes and read data. Configuration space always uses the little-endian mapping.
- R9: A completed data phase with `frame_n` high is the last one. In the next clock `devsel_n` and `trdy_n` are high and `ad_oe` and `ctl_oe` are low.
- R10: `ctl_oe` is high exactly while the target holds the cycle claimed. `ad_oe` is high only during a claimed read, and `ad_out` then carries the word at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all phases begin on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n | input | 1 | Active-low transaction frame strobe |
| irdy_n | input | 1 | Active-low initiator ready |
| idsel | input | 1 | Configuration select qualifier |
| big_endian | input | 1 | Lane mapping select, 1 = reversed byte order |
| devsel_n | output | 1 | Active-low device select (claim) |
| trdy_n | output | 1 | Active-low target ready |
| ctl_oe | output | 1 | Output enable for `devsel_n` and `trdy_n` |

## Verification
The checker watches the handshake on every clock: claim or no claim one clock after each address phase, target ready never without device select, pointer hold on wait states, pointer step on non-final transfers, release after the final phase, and read output enable only inside a claim. What lands in storage can only be shown by the bench scenarios, which write and read back data through the bus. These cover byte-lane merging in both endian modes, burst wrap-around, the base register moving the window, and misses or unsupported commands leaving memory untouched.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_SKIP = 2'd2
  } tgt_state_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [5:0] CFG_BAR_IDX = 6'd4;

  // reverse byte order of a word
  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // reverse lane-enable order
  function automatic logic [3:0] swap_lanes(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

  // merge new bytes into old where the active-low enable is 0
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  en_n);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = en_n[i] ? old_w[8*i +: 8] : new_w[8*i +: 8];
    return r;
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [31:AW] addr_hi,
  input  logic [1:0]   addr_lo,
  input  logic [3:0]   cmd,
  input  logic         idsel,
  input  logic [31:AW] bar_hi,
  output logic         hit,
  output logic         is_cfg,
  output logic         is_read
);
  logic mem_cmd, cfg_cmd;

  always_comb begin
    mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    cfg_cmd = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    is_cfg  = cfg_cmd;
    is_read = (cmd == CMD_MEM_RD) || (cmd == CMD_CFG_RD);
    hit     = (mem_cmd && (addr_hi == bar_hi)) ||
              (cfg_cmd && idsel && (addr_lo == 2'b00));
  end
endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile
  import pci_tgt_pkg::*;
#(
  parameter int          WORDS    = 8,
  parameter logic [31:0] BAR_INIT = 32'h1000_0000,
  localparam int         IW       = $clog2(WORDS),
  localparam int         AW       = IW + 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        is_cfg,
  input  logic [5:0]  ptr,
  input  logic        big,
  input  logic [31:0] wdata,
  input  logic [3:0]  be_n,
  output logic [31:0] rdata,
  output logic [31:0] bar
);
  localparam logic [31:0] BAR_MASK = ~((32'd1 << AW) - 32'd1);

  logic [31:0] mem [WORDS];
  logic [IW-1:0] idx;
  logic [31:0] mem_wd;
  logic [3:0]  mem_be;
  logic        cfg_bar_sel;

  always_comb begin
    idx         = ptr[IW-1:0];
    mem_wd      = big ? swap_bytes(wdata) : wdata;
    mem_be      = big ? swap_lanes(be_n)  : be_n;
    cfg_bar_sel = (ptr == CFG_BAR_IDX);
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && !is_cfg && (idx == IW'(g)))
        mem[g] <= merge_bytes(mem[g], mem_wd, mem_be);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bar <= BAR_INIT & BAR_MASK;
    else if (we && is_cfg && cfg_bar_sel)
      bar <= merge_bytes(bar, wdata, be_n) & BAR_MASK;
  end

  always_comb begin
    if (is_cfg)
      rdata = cfg_bar_sel ? bar : 32'd0;
    else
      rdata = big ? swap_bytes(mem[idx]) : mem[idx];
  end
endmodule

// File: rtl/pci_tgt_core.sv
module pci_tgt_core
  import pci_tgt_pkg::*;
#(
  parameter int          WORDS    = 8,
  parameter logic [31:0] BAR_INIT = 32'h1000_0000,
  localparam int         IW       = $clog2(WORDS),
  localparam int         AW       = IW + 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic        big_endian,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        ctl_oe
);
  tgt_state_t  state;
  logic        rd_q, cfg_q;
  logic [5:0]  ptr;
  logic [31:0] bar;
  logic        dec_hit, dec_cfg, dec_rd;

  // named events for the checker
  logic addr_phase, claim, xfer_done, last_phase, wr_en;

  pci_tgt_decode #(.AW(AW)) u_dec (
    .addr_hi (ad_in[31:AW]),
    .addr_lo (ad_in[1:0]),
    .cmd     (cbe_n),
    .idsel   (idsel),
    .bar_hi  (bar[31:AW]),
    .hit     (dec_hit),
    .is_cfg  (dec_cfg),
    .is_read (dec_rd)
  );

  always_comb begin
    addr_phase = (state == ST_IDLE) && !frame_n;
    claim      = addr_phase && dec_hit;
    xfer_done  = (state == ST_XFER) && !irdy_n;
    last_phase = xfer_done && frame_n;
    wr_en      = xfer_done && !rd_q;
  end

  pci_tgt_regfile #(.WORDS(WORDS), .BAR_INIT(BAR_INIT)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en),
    .is_cfg (cfg_q),
    .ptr    (ptr),
    .big    (big_endian),
    .wdata  (ad_in),
    .be_n   (cbe_n),
    .rdata  (ad_out),
    .bar    (bar)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rd_q  <= 1'b0;
      cfg_q <= 1'b0;
      ptr   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (addr_phase) begin
          state <= claim ? ST_XFER : ST_SKIP;
          rd_q  <= dec_rd;
          cfg_q <= dec_cfg;
          ptr   <= ad_in[7:2];
        end
        ST_XFER: if (xfer_done) begin
          ptr <= ptr + 6'd1;
          if (frame_n) state <= ST_IDLE;
        end
        ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl_oe   = (state == ST_XFER);
    devsel_n = !ctl_oe;
    trdy_n   = !ctl_oe;
    ad_oe    = ctl_oe && rd_q;
  end
endmodule

// File: rtl/pci_tgt_checker.sv
module pci_tgt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       ad_oe,
  input logic       ctl_oe,
  input logic       addr_phase,
  input logic       claim,
  input logic       xfer_done,
  input logic [5:0] ptr
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (devsel_n && trdy_n && !ad_oe && !ctl_oe));

  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (!devsel_n && !trdy_n));

  p_no_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !claim) |=> devsel_n);

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && irdy_n) |=> $stable(ptr));

  p_trdy_in_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !frame_n) |=> (ptr == $past(ptr) + 6'd1));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && frame_n) |=> (devsel_n && trdy_n && !ad_oe && !ctl_oe));

  p_ad_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (ctl_oe && !devsel_n));
endmodule

bind pci_tgt_core pci_tgt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .devsel_n   (devsel_n),
  .trdy_n     (trdy_n),
  .ad_oe      (ad_oe),
  .ctl_oe     (ctl_oe),
  .addr_phase (addr_phase),
  .claim      (claim),
  .xfer_done  (xfer_done),
  .ptr        (ptr)
);

// File: tb/sim_pci_tgt_core.sv
`timescale 1ns/1ps
module sim_pci_tgt_core;
  localparam int WORDS = 8;
  localparam int AWB   = 5;
  localparam logic [31:0] MASK = ~((32'd1 << AWB) - 32'd1);

  logic        clk = 0, rst_n = 0;
  logic [31:0] ad_in = 0, ad_out;
  logic        ad_oe, devsel_n, trdy_n, ctl_oe;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1, irdy_n = 1, idsel = 0, big_endian = 0;

  pci_tgt_core #(.WORDS(WORDS), .BAR_INIT(32'h1000_0000)) u0 (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .big_endian(big_endian), .devsel_n(devsel_n), .trdy_n(trdy_n), .ctl_oe(ctl_oe));

  always #2 clk = ~clk;

  int errs = 0, checks = 0;
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_bar = 32'h1000_0000;
  logic [31:0] wd  [16];
  logic [3:0]  wbe [16];
  logic [31:0] exp_q [$];
  string       req_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*(3-i) +: 8] = w[8*i +: 8];
    return r;
  endfunction

  // scoreboard monitor: compare read data on each completed read phase
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && !irdy_n && !trdy_n && ad_oe) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected read", ad_out, 32'h0);
      else begin
        logic [31:0] e; string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        chk(ad_out === e, r, ad_out, e);
      end
    end
  end

  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input bit idv,
                      input int n, input bit claim_exp, input int wait_at, input string req);
    bit rd, cfg;
    int w;
    logic [5:0] off;
    rd  = (cmd == 4'b0110) || (cmd == 4'b1010);
    cfg = (cmd == 4'b1010) || (cmd == 4'b1011);
    if (claim_exp && rd)
      for (int k = 0; k < n; k++) begin
        if (cfg) begin
          off = addr[7:2] + 6'(k);
          exp_q.push_back(off == 6'd4 ? m_bar : 32'd0);
        end else begin
          w = (int'(addr[7:2]) + k) % WORDS;
          exp_q.push_back(big_endian ? rev(m_mem[w]) : m_mem[w]);
        end
        req_q.push_back(req);
      end
    @(negedge clk);
    frame_n = 0; ad_in = addr; cbe_n = cmd; idsel = idv; irdy_n = 1;
    @(negedge clk);
    idsel = 0;
    chk(devsel_n == !claim_exp, {req, " claim"}, 32'(devsel_n), 32'(!claim_exp));
    chk(ad_oe == (claim_exp && rd), {"R10 ", req}, 32'(ad_oe), 32'(claim_exp && rd));
    for (int i = 0; i < n; i++) begin
      if (i == wait_at) begin
        irdy_n = 1; frame_n = 0; ad_in = 32'hDEAD_BEEF; cbe_n = 4'h0;
        @(negedge clk);
      end
      ad_in = wd[i]; cbe_n = wbe[i]; irdy_n = 0; frame_n = (i == n - 1);
      if (claim_exp && !rd) begin
        if (cfg) begin
          off = addr[7:2] + 6'(i);
          if (off == 6'd4) begin
            for (int b = 0; b < 4; b++) if (!wbe[i][b]) m_bar[8*b +: 8] = wd[i][8*b +: 8];
            m_bar &= MASK;
          end
        end else begin
          w = (int'(addr[7:2]) + i) % WORDS;
          for (int b = 0; b < 4; b++)
            if (!wbe[i][b]) m_mem[w][8*(big_endian ? 3-b : b) +: 8] = wd[i][8*b +: 8];
        end
      end
      @(negedge clk);
    end
    irdy_n = 1; frame_n = 1; cbe_n = 4'hF;
    chk(devsel_n && trdy_n && !ctl_oe && !ad_oe, {"R9 release ", req},
        {devsel_n, trdy_n, ctl_oe, ad_oe}, 32'hC);
    @(negedge clk);
  endtask

  task automatic fill(input int n, input logic [31:0] seed, input logic [3:0] be);
    for (int i = 0; i < n; i++) begin wd[i] = seed + 32'h0101_0101 * i; wbe[i] = be; end
  endtask

  localparam logic [31:0] B = 32'h2000_0000;

  initial begin
    for (int i = 0; i < WORDS; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe && !ctl_oe, "R1 reset outputs",
        {devsel_n, trdy_n, ad_oe, ctl_oe}, 32'hC);
    rst_n = 1;
    @(negedge clk);
    chk(devsel_n && trdy_n && !ctl_oe, "R1 idle after reset", {devsel_n, trdy_n, ctl_oe}, 32'h6);
    // R1/R4: base register reset value via config read
    fill(1, 0, 4'h0);
    xact(4'b1010, 32'h10, 1, 1, 1, -1, "R1 bar reset");
    // R4: config write with idsel low is ignored
    wd[0] = 32'h3000_0000; wbe[0] = 4'h0;
    xact(4'b1011, 32'h10, 0, 1, 0, -1, "R4 cfg idsel low");
    xact(4'b1010, 32'h10, 1, 1, 1, -1, "R4 bar unchanged");
    // R4: set base, low bits forced zero
    wd[0] = B | 32'h1C; wbe[0] = 4'h0;
    xact(4'b1011, 32'h10, 1, 1, 1, -1, "R4 cfg write");
    xact(4'b1010, 32'h10, 1, 1, 1, -1, "R4 bar readback");
    xact(4'b1010, 32'h14, 1, 1, 1, -1, "R4 other offset zero");
    // R2/R6: full burst write and read
    fill(8, 32'h1020_3040, 4'h0);
    xact(4'b0111, B, 0, 8, 1, -1, "R2 burst write");
    xact(4'b0110, B, 0, 8, 1, -1, "R6 burst read");
    // R6: wrapping burst
    fill(4, 32'hA0B0_C0D0, 4'h0);
    xact(4'b0111, B + 32'h18, 0, 4, 1, -1, "R6 wrap write");
    xact(4'b0110, B + 32'h18, 0, 4, 1, -1, "R6 wrap read");
    // R5: wait states on write and read
    fill(3, 32'h5566_7788, 4'h0);
    xact(4'b0111, B + 32'h8, 0, 3, 1, 1, "R5 wait write");
    xact(4'b0110, B + 32'h8, 0, 3, 1, 2, "R5 wait read");
    // R7: partial lanes, little endian
    wd[0] = 32'hFFEE_DDCC; wbe[0] = 4'b1010;
    xact(4'b0111, B + 32'h4, 0, 1, 1, -1, "R7 partial write");
    xact(4'b0110, B + 32'h4, 0, 1, 1, -1, "R7 partial read");
    // R8: big endian
    big_endian = 1;
    wd[0] = 32'h1122_3344; wbe[0] = 4'h0;
    xact(4'b0111, B, 0, 1, 1, -1, "R8 big write");
    wd[0] = 32'hAA00_0000; wbe[0] = 4'b0111;
    xact(4'b0111, B + 32'h4, 0, 1, 1, -1, "R8 big lane3");
    xact(4'b0110, B, 0, 2, 1, -1, "R8 big read");
    big_endian = 0;
    xact(4'b0110, B, 0, 2, 1, -1, "R8 little view");
    // R3: misses and unsupported command
    fill(2, 32'h0BAD_0BAD, 4'h0);
    xact(4'b0111, 32'h1000_0000, 0, 2, 0, -1, "R3 out of window");
    xact(4'b0011, B, 0, 1, 0, -1, "R3 io write");
    xact(4'b0110, 32'h4000_0000, 0, 1, 0, -1, "R3 read miss");
    xact(4'b0110, B, 0, 8, 1, -1, "R3 memory unchanged");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog R1 act=%h exp=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule